// File: doc/BRIEF.md
# Programmable Interval Down-Counter Timer

This block is a 32-bit interval timer. Software sets it up through a small synchronous register port with a word address. The counter loads a start value and counts down toward zero at the bus clock rate divided by a selectable prescaler. When it reaches zero it emits a one-cycle interrupt pulse, unless interrupts are masked. It then either reloads and keeps running (periodic mode) or parks at zero (one-shot mode).

Software programs the mode and mask bits, the prescaler code and the start value. The remaining count can be read back at any time, so the block can also serve as a free-running time base. Writing a new start value restarts the countdown from that value. Writing zero stops the timer.

The register map uses these word offsets:

| Offset | Register | Contents |
|---|---|---|
| 0x0 | control | bit 16 = mask, bit 17 = periodic |
| 0x1 | start value | last value written |
| 0x2 | remaining count | read-only |
| 0x3 | prescaler code | low 4 bits |

Top module: `intvl_timer`

## Requirements
- R1: After reset the start-value register (offset 0x1), the remaining count (offset 0x2) and the prescaler code (offset 0x3) read 0, and `irq` is low. The control register (offset 0x0) reads 0x0001_0000: mask set, one-shot mode.
- R2: A write to offset 0x1 takes effect in the following cycle. Offset 0x1 then reads back the written value, offset 0x2 holds that value, and the prescaler phase restarts.
- R3: The remaining count drops by exactly one at the end of each prescaler period and holds otherwise. Prescaler codes give these ratios: 0x0 = ÷2, 0x1 = ÷4, 0x2 = ÷8, 0x3 = ÷16, 0x8 = ÷32, 0x9 = ÷64, 0xA = ÷128, 0xB = ÷1. Only bits 3:0 of offset 0x3 are stored.
- R4: A prescaler code with bit 2 set divides as the code with bit 2 cleared, for example 0xF = ÷1 and 0x4 = ÷2.
- R5: A new prescaler code takes effect only at the next prescaler period boundary (or at the next start-value write). The period already in progress finishes at the old ratio.
- R6: When the count steps from 1 to 0, an expiry pulse occurs for exactly one cycle. The pulse is in the cycle in which the count first reads 0.
- R7: `irq` equals the expiry pulse when the mask bit (offset 0x0 bit 16) is 0, and stays low while the mask bit is 1. Clearing the mask lets the next expiry through.
- R8: In periodic mode (offset 0x0 bit 17 = 1), the counter reloads the start value at the first prescaler boundary after reaching zero. The interval between expiries is therefore (start value + 1) prescaler periods.
- R9: In one-shot mode the counter stays at zero after expiry, with no further pulses, until offset 0x1 is written again.
- R10: Writing 0 to offset 0x1 stops the timer: the count reads 0 and no expiry pulse occurs.
- R11: Writes to offset 0x2 are ignored. Reads of offsets above 0x3 return 0.
- R12: A start-value write that lands on the same cycle as a prescaler boundary takes priority over the decrement or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busAddr | input | ADDR_W | Word offset of the register |
| busWData | input | CNT_W | Write data |
| busRData | output | CNT_W | Read data of the addressed register, same cycle |
| irq | output | 1 | One-cycle interrupt pulse per unmasked expiry |

## Verification
Every divide code, both defined and aliased, is run with a short periodic start value. Comparing the decrement spacing and the expiry spacing against an independent model shows whether the ratio decode and the reload arithmetic are each right. One-shot runs, mask toggling and a zero write check whether the timer stops, whether it is muted, or whether it is still counting. Divide changes in mid-period and start-value writes under ÷1 put a write on the same cycle as a boundary. These runs show whether the boundary latching and the write priority are ordered correctly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;
  localparam int SH_W     = 3;
  localparam int PS_W     = 7;

  typedef struct packed {
    logic load;
    logic tick;
    logic periodic;
  } tmrStrobe_t;

  // Bit 2 of the code is ignored; bit 3 selects the upper ratio group.
  function automatic logic [SH_W-1:0] divToShift(input logic [3:0] code);
    logic [SH_W-1:0] low;
    low = {1'b0, code[1:0]};
    if (!code[3])               return low + 3'd1;
    else if (code[1:0] == 2'b11) return 3'd0;
    else                         return low + 3'd5;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] divCode,
  output logic             tick
);
  logic [SH_W-1:0] shiftQ;
  logic [PS_W-1:0] psQ;
  logic [PS_W-1:0] termVal;

  assign termVal = ({{(PS_W-1){1'b0}}, 1'b1} << shiftQ) - 1'b1;
  assign tick    = (psQ == termVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psQ    <= '0;
      shiftQ <= divToShift(4'h0);
    end else if (restart || tick) begin
      psQ    <= '0;
      shiftQ <= divToShift(divCode[3:0]);
    end else begin
      psQ <= psQ + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWData,
  input  logic [CNT_W-1:0]  cntQ,
  output logic [CNT_W-1:0]  busRData,
  output logic [CNT_W-1:0]  initQ,
  output logic              maskQ,
  output tmrStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_INIT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_CUR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_DIV  = ADDR_W'(3);

  logic             periodicQ;
  logic [DIV_W-1:0] divQ;
  logic             tickS;

  tmr_prescale #(.DIV_W(DIV_W)) u_ps (
    .clk(clk), .rstN(rstN), .restart(stb.load), .divCode(divQ), .tick(tickS)
  );

  always_comb begin
    stb.load     = busWrEn && (busAddr == OFF_INIT);
    stb.tick     = tickS;
    stb.periodic = periodicQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= 1'b1;
      periodicQ <= 1'b0;
      initQ     <= '0;
      divQ      <= '0;
    end else if (busWrEn) begin
      case (busAddr)
        OFF_CTRL: begin
          maskQ     <= busWData[MASK_BIT];
          periodicQ <= busWData[MODE_BIT];
        end
        OFF_INIT: initQ <= busWData;
        OFF_DIV:  divQ  <= busWData[DIV_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    busRData = '0;
    case (busAddr)
      OFF_CTRL: begin
        busRData[MASK_BIT] = maskQ;
        busRData[MODE_BIT] = periodicQ;
      end
      OFF_INIT: busRData = initQ;
      OFF_CUR:  busRData = cntQ;
      OFF_DIV:  busRData[DIV_W-1:0] = divQ;
      default:  busRData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initQ,
  output logic [CNT_W-1:0] cntQ,
  output logic             expireQ,
  output logic             armedQ
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      expireQ <= 1'b0;
      armedQ  <= 1'b0;
    end else begin
      expireQ <= 1'b0;
      if (stb.load) begin
        cntQ   <= loadVal;
        armedQ <= |loadVal;
      end else if (stb.tick && armedQ) begin
        if (cntQ == '0) begin
          if (stb.periodic) cntQ   <= initQ;
          else              armedQ <= 1'b0;
        end else begin
          cntQ <= cntQ - ONE;
          if (cntQ == ONE) begin
            expireQ <= 1'b1;
            if (!stb.periodic) armedQ <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/intvl_timer.sv
module intvl_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWData,
  output logic [CNT_W-1:0]  busRData,
  output logic              irq
);
  tmrStrobe_t       stb;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] initQ;
  logic             maskQ;
  logic             expireQ;
  logic             armedQ;

  tmr_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWData(busWData), .cntQ(cntQ), .busRData(busRData),
    .initQ(initQ), .maskQ(maskQ), .stb(stb)
  );

  tmr_dpath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(busWData), .initQ(initQ),
    .cntQ(cntQ), .expireQ(expireQ), .armedQ(armedQ)
  );

  assign irq = expireQ & ~maskQ;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadS,
  input logic             tickS,
  input logic             periodic,
  input logic             armed,
  input logic             mask,
  input logic             expire,
  input logic             irq,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] initQ,
  input logic [CNT_W-1:0] loadVal
);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadS |=> (cntQ == $past(loadVal)) && (initQ == $past(loadVal)));
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadS && !tickS) |=> $stable(cntQ));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R6
  expire_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> (cntQ == '0));
  // R7
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    mask |-> !irq);
  // R8
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickS && !loadS && armed && periodic && cntQ == '0) |=> (cntQ == $past(initQ)));
  // R9
  oneshot_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickS && !loadS && !periodic && cntQ == '0) |=> (cntQ == '0));
endmodule

bind intvl_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadS(stb.load), .tickS(stb.tick),
  .periodic(stb.periodic), .armed(armedQ), .mask(maskQ), .expire(expireQ),
  .irq(irq), .cntQ(cntQ), .initQ(initQ), .loadVal(busWData)
);

// File: tb/sim_intvl_timer.sv
`timescale 1ns/1ps
module sim_intvl_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  longint mCnt = 0, mInit = 0, mPs = 0, mRatio = 2;
  int mDiv = 0;
  bit mMask = 1, mPer = 0, mArmed = 0, mExp = 0;

  always #5 clk = ~clk;

  intvl_timer u0 (.clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
                  .busWData(busWData), .busRData(busRData), .irq(irq));

  function automatic longint ratioOf(int code);
    case (code & 11)
      0: return 2;   1: return 4;   2: return 8;   3: return 16;
      8: return 32;  9: return 64;  10: return 128; 11: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint expRead(int a);
    case (a)
      0: return (longint'(mPer) << 17) | (longint'(mMask) << 16);
      1: return mInit;
      2: return mCnt;
      3: return mDiv;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit tick, ld;
    cycles++;
    if (!rstN) begin
      mCnt = 0; mInit = 0; mPs = 0; mRatio = 2; mDiv = 0;
      mMask = 1; mPer = 0; mArmed = 0; mExp = 0;
    end else begin
      tick = (mPs == mRatio - 1);
      ld = busWrEn && busAddr == 1;
      mExp = 0;
      if (ld || tick) begin mPs = 0; mRatio = ratioOf(mDiv); end
      else mPs++;
      if (ld) begin
        mCnt = busWData; mArmed = (busWData != 0);
      end else if (tick && mArmed) begin
        if (mCnt == 0) begin
          if (mPer) mCnt = mInit; else mArmed = 0;
        end else begin
          mCnt--;
          if (mCnt == 0) begin mExp = 1; if (!mPer) mArmed = 0; end
        end
      end
      if (busWrEn) begin
        case (busAddr)
          0: begin mMask = busWData[16]; mPer = busWData[17]; end
          1: mInit = busWData;
          3: mDiv = busWData[3:0];
          default: ;
        endcase
      end
      #2;
      check(busRData == 32'(expRead(busAddr)), curReq, busRData, expRead(busAddr));
      check(irq == (mExp && !mMask), curReq, irq, mExp && !mMask);
    end
  end

  task automatic wr(int a, longint d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 4'(a); busWData = 32'(d);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 4'd2;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int codes[12] = '{0, 1, 2, 3, 8, 9, 10, 11, 4, 7, 12, 15};
    busAddr = 4'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state at the ports
    check(busRData == 32'h0001_0000, "R1", busRData, 32'h0001_0000);
    check(irq == 1'b0, "R1", irq, 0);
    for (int a = 1; a < 4; a++) begin
      busAddr = 4'(a); #1;
      check(busRData == 0, "R1", busRData, 0);
    end
    busAddr = 4'd2;
    @(negedge clk);

    curReq = "R2"; wr(0, 0); wr(3, 'hB); wr(1, 5); idle(3);
    curReq = "R6"; idle(4);
    curReq = "R9"; idle(20);
    curReq = "R9"; wr(1, 2); idle(10);

    curReq = "R8"; wr(0, 32'h0002_0000); wr(1, 3); idle(30);

    foreach (codes[i]) begin
      curReq = (codes[i] & 4) ? "R4" : "R3";
      wr(3, codes[i]); wr(1, 2);
      idle(int'(ratioOf(codes[i])) * 7 + 4);
    end

    curReq = "R5"; wr(3, 3); wr(1, 4); idle(7); wr(3, 'hB); idle(20);
    wr(3, 1); idle(5); wr(3, 0); idle(30);

    curReq = "R7"; wr(3, 'hB); wr(0, 32'h0003_0000); wr(1, 2); idle(15);
    wr(0, 32'h0002_0000); idle(15);

    curReq = "R12";
    for (int k = 1; k < 6; k++) wr(1, k);
    idle(12);

    curReq = "R10"; wr(1, 0); idle(20);
    curReq = "R10"; wr(1, 3); idle(2); wr(1, 0); idle(10);

    curReq = "R11"; wr(1, 6); wr(2, 32'h1234); idle(3);
    for (int a = 4; a < 16; a++) begin
      @(negedge clk); busAddr = 4'(a);
    end
    @(negedge clk); busAddr = 4'd2;
    wr(7, 32'hFFFF_FFFF); idle(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule